// File: doc/BRIEF.md
# Command-Indexed Memory Bank Switcher

This block sits on the cartridge side of an 8-bit CPU system with a 16-bit CPU address bus and a separate 14-bit video bus. It remaps CPU addresses in 0x6000–0xFFFF onto a larger program ROM or a battery-style work RAM, and video addresses in 0x0000–0x1FFF onto a larger pattern memory. It also reports a nametable mirroring mode. It drives only addresses, enables and write strobes. The memories themselves sit outside the block.

Software programs the block in two steps. A write into 0x8000–0x9FFF picks one of sixteen command slots. A following write into 0xA000–0xBFFF deposits the data byte into the register that slot names. The resulting bank registers steer four 8 KiB CPU windows and eight 1 KiB video slots. Every translation and enable is registered, so the memory side sees it one clock after the bus cycle that caused it.

Top module: `bsw_top`

## Requirements
- R1: A CPU write (cpu_wr=1) with cpu_addr[15:13]=3'b100 latches cpu_wdata[3:0] as the command number. The upper nibble is discarded.
- R2: A CPU write with cpu_addr[15:13]=3'b101 stores cpu_wdata in the register the command selects: 0–7 pattern slots 0–7, 8 low-window bank, 9/10/11 the 0x8000/0xA000/0xC000 banks, 12 mirroring. Commands 13–15 leave every observable output unchanged.
- R3: Command 12 sets mirror_mode to cpu_wdata[1:0]: 0 vertical, 1 horizontal, 2 single page 0, 3 single page 1.
- R4: A CPU read in 0x8000–0xDFFF raises prg_rom_en. prg_addr = {bank mod 2^PRG_BANK_BITS, cpu_addr[12:0]}, where the bank comes from register 9, 10 or 11.
- R5: A CPU read in 0xE000–0xFFFF always maps to the last ROM bank (all ones).
- R6: In 0x6000–0x7FFF, low-window register bits [7:6] equal to 2'b11 select RAM. Otherwise a read goes to ROM bank reg[5:0] mod 2^PRG_BANK_BITS. RAM accesses raise wram_en, use wram_addr = {reg bank bits, cpu_addr[12:0]}, and raise wram_we only on writes.
- R7: RAM that is selected with a bank number at or beyond 2^WRAM_BANK_BITS is unusable. A read then raises open_bus_en with open_bus_data = cpu_addr[15:8]. A write then leaves wram_en and wram_we low.
- R8: A video access with ppu_addr[13]=0 raises chr_en. chr_addr = {pattern register[ppu_addr[12:10]] mod 2^CHR_BANK_BITS, ppu_addr[9:0]}.
- R9: chr_we is high only for a video write in range and only when CHR_IS_RAM is nonzero. When it is zero, writes give chr_en with chr_we low.
- R10: Reset clears the command and pattern banks to 0. Bank registers 8/9/10/11 become 0/0/1/2, mirroring becomes vertical, and every enable becomes low.
- R11: All outputs register the cycle's inputs against the register state before that cycle's edge. A register write takes effect on translations one cycle later.
- R12: Accesses below 0x6000, or cycles with no read or write strobe, raise no CPU-side enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | Video address |
| ppu_rd | input | 1 | Video read strobe |
| ppu_wr | input | 1 | Video write strobe |
| prg_addr | output | 13+PRG_BANK_BITS | Program ROM address |
| prg_rom_en | output | 1 | Program ROM read enable |
| wram_addr | output | 13+WRAM_BANK_BITS | Work RAM address |
| wram_en | output | 1 | Work RAM enable |
| wram_we | output | 1 | Work RAM write strobe |
| open_bus_en | output | 1 | Open-bus read indicator |
| open_bus_data | output | 8 | Open-bus value |
| chr_addr | output | 10+CHR_BANK_BITS | Pattern memory address |
| chr_en | output | 1 | Pattern memory enable |
| chr_we | output | 1 | Pattern memory write strobe |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A CPU parameter write that retargets a pattern slot can land in the same cycle as a video read of that slot. The bench provokes this by writing each of the eight pattern registers while the video bus reads the slot being rewritten. The registered chr_addr for that cycle must still carry the old bank, and the new bank must appear from the next access on. A behavioural reference model, updated after it forms its prediction on each edge, judges every cycle.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int unsigned CMD_W      = 4;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned NUM_SLOTS  = 8;
  localparam int unsigned WIN_OFS_W  = 13;
  localparam int unsigned SLOT_OFS_W = 10;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam logic [2:0] WIN_LOW  = 3'b011;
  localparam logic [2:0] WIN_CMD  = 3'b100;
  localparam logic [2:0] WIN_PARM = 3'b101;
  localparam logic [2:0] WIN_C    = 3'b110;
  localparam logic [2:0] WIN_TOP  = 3'b111;
endpackage

// File: rtl/bsw_cmd_regs.sv
module bsw_cmd_regs
  import bsw_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [2:0]                           win,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]     chr_banks,
  output logic [DATA_W-1:0]                    low_bank,
  output logic [DATA_W-1:0]                    bank_8k,
  output logic [DATA_W-1:0]                    bank_ak,
  output logic [DATA_W-1:0]                    bank_ck,
  output mirror_e                              mirror
);
  logic [CMD_W-1:0] cmd;
  logic             parm_wr;

  assign parm_wr = wr_en && (win == WIN_PARM);

  always_ff @(posedge clk) begin
    if (rst)                         cmd <= '0;
    else if (wr_en && win == WIN_CMD) cmd <= wdata[CMD_W-1:0];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                chr_banks[s] <= '0;
      else if (parm_wr && cmd == CMD_W'(s))   chr_banks[s] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_bank <= 8'd0;
      bank_8k  <= 8'd0;
      bank_ak  <= 8'd1;
      bank_ck  <= 8'd2;
      mirror   <= MIR_VERT;
    end else if (parm_wr) begin
      case (cmd)
        4'd8:    low_bank <= wdata;
        4'd9:    bank_8k  <= wdata;
        4'd10:   bank_ak  <= wdata;
        4'd11:   bank_ck  <= wdata;
        4'd12:   mirror   <= mirror_e'(wdata[1:0]);
        default: ;
      endcase
    end
  end

  AST_CMD_LATCH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && win == WIN_CMD) |=> (cmd == $past(wdata[CMD_W-1:0]))); // R1
  AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (rst)
    (parm_wr && cmd > 4'd12) |=> ($stable(chr_banks) && $stable(low_bank) &&
      $stable(bank_8k) && $stable(bank_ak) && $stable(bank_ck) && $stable(mirror))); // R2
  AST_MIRROR_SRC: assert property (@(posedge clk) disable iff (rst)
    !$stable(mirror) |-> $past(parm_wr && cmd == 4'd12)); // R3
endmodule

// File: rtl/bsw_prg_map.sv
module bsw_prg_map
  import bsw_pkg::*;
#(
  parameter int unsigned PRG_BANK_BITS  = 5,
  parameter int unsigned WRAM_BANK_BITS = 1,
  localparam int unsigned PRG_AW  = WIN_OFS_W + PRG_BANK_BITS,
  localparam int unsigned WRAM_AW = WIN_OFS_W + WRAM_BANK_BITS
) (
  input  logic [15:0]         addr,
  input  logic                rd,
  input  logic                wr,
  input  logic [DATA_W-1:0]   low_bank,
  input  logic [DATA_W-1:0]   bank_8k,
  input  logic [DATA_W-1:0]   bank_ak,
  input  logic [DATA_W-1:0]   bank_ck,
  output logic [PRG_AW-1:0]   prg_addr,
  output logic                rom_en,
  output logic [WRAM_AW-1:0]  ram_addr,
  output logic                ram_en,
  output logic                ram_we,
  output logic                ob_en
);
  logic [2:0]        win;
  logic [DATA_W-1:0] sel;
  logic              ram_sel, ram_ok, in_rom;
  logic [5:0]        low_num;

  assign win     = addr[15:13];
  assign low_num = low_bank[5:0];

  always_comb begin
    case (win)
      WIN_LOW:  sel = {2'b00, low_num};
      WIN_CMD:  sel = bank_8k;
      WIN_PARM: sel = bank_ak;
      WIN_C:    sel = bank_ck;
      WIN_TOP:  sel = '1;
      default:  sel = '0;
    endcase
  end

  assign ram_sel = (win == WIN_LOW) && low_bank[6] && low_bank[7];
  assign ram_ok  = ram_sel && ((low_num >> WRAM_BANK_BITS) == 6'd0);
  assign in_rom  = win[2] || ((win == WIN_LOW) && !ram_sel);

  assign prg_addr = {sel[PRG_BANK_BITS-1:0], addr[WIN_OFS_W-1:0]};
  assign ram_addr = {low_num[WRAM_BANK_BITS-1:0], addr[WIN_OFS_W-1:0]};
  assign rom_en   = rd && in_rom;
  assign ram_en   = (rd || wr) && ram_ok;
  assign ram_we   = wr && ram_ok;
  assign ob_en    = rd && ram_sel && !ram_ok;

  logic unused_sel;
  assign unused_sel = ^sel;
endmodule

// File: rtl/bsw_chr_map.sv
module bsw_chr_map
  import bsw_pkg::*;
#(
  parameter int unsigned CHR_BANK_BITS = 8,
  parameter int unsigned CHR_IS_RAM    = 0,
  localparam int unsigned CHR_AW = SLOT_OFS_W + CHR_BANK_BITS
) (
  input  logic [13:0]                       addr,
  input  logic                              rd,
  input  logic                              wr,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  banks,
  output logic [CHR_AW-1:0]                 chr_addr,
  output logic                              en,
  output logic                              we
);
  logic [2:0]        slot;
  logic [DATA_W-1:0] bank;
  logic              in_rng;

  assign slot     = addr[12:10];
  assign bank     = banks[slot];
  assign in_rng   = !addr[13];
  assign chr_addr = {bank[CHR_BANK_BITS-1:0], addr[SLOT_OFS_W-1:0]};
  assign en       = in_rng && (rd || wr);

  if (CHR_IS_RAM != 0) begin : g_ram
    assign we = in_rng && wr;
  end else begin : g_rom
    assign we = 1'b0;
  end

  logic unused_bank;
  assign unused_bank = ^bank;
endmodule

// File: rtl/bsw_top.sv
module bsw_top
  import bsw_pkg::*;
#(
  parameter int unsigned PRG_BANK_BITS  = 5,
  parameter int unsigned WRAM_BANK_BITS = 1,
  parameter int unsigned CHR_BANK_BITS  = 8,
  parameter int unsigned CHR_IS_RAM     = 0,
  localparam int unsigned PRG_AW  = WIN_OFS_W + PRG_BANK_BITS,
  localparam int unsigned WRAM_AW = WIN_OFS_W + WRAM_BANK_BITS,
  localparam int unsigned CHR_AW  = SLOT_OFS_W + CHR_BANK_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [13:0]        ppu_addr,
  input  logic               ppu_rd,
  input  logic               ppu_wr,
  output logic [PRG_AW-1:0]  prg_addr,
  output logic               prg_rom_en,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic               wram_en,
  output logic               wram_we,
  output logic               open_bus_en,
  output logic [7:0]         open_bus_data,
  output logic [CHR_AW-1:0]  chr_addr,
  output logic               chr_en,
  output logic               chr_we,
  output logic [1:0]         mirror_mode
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] chr_banks;
  logic [DATA_W-1:0] low_bank, bank_8k, bank_ak, bank_ck;
  mirror_e           mirror;

  logic [PRG_AW-1:0]  prg_addr_d;
  logic [WRAM_AW-1:0] wram_addr_d;
  logic [CHR_AW-1:0]  chr_addr_d;
  logic rom_en_d, ram_en_d, ram_we_d, ob_en_d, chr_en_d, chr_we_d;

  bsw_cmd_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .win(cpu_addr[15:13]), .wdata(cpu_wdata),
    .chr_banks(chr_banks), .low_bank(low_bank), .bank_8k(bank_8k),
    .bank_ak(bank_ak), .bank_ck(bank_ck), .mirror(mirror)
  );

  bsw_prg_map #(.PRG_BANK_BITS(PRG_BANK_BITS), .WRAM_BANK_BITS(WRAM_BANK_BITS)) u_prg (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .low_bank(low_bank),
    .bank_8k(bank_8k), .bank_ak(bank_ak), .bank_ck(bank_ck),
    .prg_addr(prg_addr_d), .rom_en(rom_en_d), .ram_addr(wram_addr_d),
    .ram_en(ram_en_d), .ram_we(ram_we_d), .ob_en(ob_en_d)
  );

  bsw_chr_map #(.CHR_BANK_BITS(CHR_BANK_BITS), .CHR_IS_RAM(CHR_IS_RAM)) u_chr (
    .addr(ppu_addr), .rd(ppu_rd), .wr(ppu_wr), .banks(chr_banks),
    .chr_addr(chr_addr_d), .en(chr_en_d), .we(chr_we_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr      <= '0;
      prg_rom_en    <= 1'b0;
      wram_addr     <= '0;
      wram_en       <= 1'b0;
      wram_we       <= 1'b0;
      open_bus_en   <= 1'b0;
      open_bus_data <= '0;
      chr_addr      <= '0;
      chr_en        <= 1'b0;
      chr_we        <= 1'b0;
      mirror_mode   <= MIR_VERT;
    end else begin
      prg_addr      <= prg_addr_d;
      prg_rom_en    <= rom_en_d;
      wram_addr     <= wram_addr_d;
      wram_en       <= ram_en_d;
      wram_we       <= ram_we_d;
      open_bus_en   <= ob_en_d;
      open_bus_data <= cpu_addr[15:8];
      chr_addr      <= chr_addr_d;
      chr_en        <= chr_en_d;
      chr_we        <= chr_we_d;
      mirror_mode   <= mirror;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prg_rom_en, wram_en, open_bus_en})); // R6
  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == WIN_TOP) |=>
      (prg_rom_en && prg_addr[PRG_AW-1:WIN_OFS_W] == '1)); // R5
  AST_RAM_WE_SRC: assert property (@(posedge clk) disable iff (rst)
    wram_we |-> $past(cpu_wr && cpu_addr[15:13] == WIN_LOW)); // R7
  AST_CHR_WE_SRC: assert property (@(posedge clk) disable iff (rst)
    chr_we |-> ((CHR_IS_RAM != 0) && $past(ppu_wr && !ppu_addr[13]))); // R9
  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15] == 1'b0 && cpu_addr[14:13] != 2'b11) |=>
      !(prg_rom_en || wram_en || open_bus_en)); // R12
endmodule

// File: tb/sim_bsw_top.sv
module sim_bsw_top;
  localparam int PB = 5, WB = 1, CB = 8, CR = 0;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [13:0] ppu_addr = '0;
  logic ppu_rd = 0, ppu_wr = 0;
  logic [13+PB-1:0] prg_addr;
  logic [13+WB-1:0] wram_addr;
  logic [10+CB-1:0] chr_addr;
  logic prg_rom_en, wram_en, wram_we, open_bus_en, chr_en, chr_we;
  logic [7:0] open_bus_data;
  logic [1:0] mirror_mode;

  always #5 clk = ~clk;

  bsw_top #(.PRG_BANK_BITS(PB), .WRAM_BANK_BITS(WB), .CHR_BANK_BITS(CB), .CHR_IS_RAM(CR)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .prg_addr(prg_addr), .prg_rom_en(prg_rom_en), .wram_addr(wram_addr), .wram_en(wram_en),
    .wram_we(wram_we), .open_bus_en(open_bus_en), .open_bus_data(open_bus_data),
    .chr_addr(chr_addr), .chr_en(chr_en), .chr_we(chr_we), .mirror_mode(mirror_mode)
  );

  int tests = 0, fails = 0;
  string phase = "";
  bit model_live = 0;

  int m_cmd, m_low, m_b8, m_ba, m_bc, m_mir;
  int m_chr[8];
  int e_rom, e_prg, e_ren, e_rwe, e_raddr, e_ob, e_obd, e_cen, e_cwe, e_caddr, e_mir;
  string t_cpu, t_chr;

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 0; m_low = 0; m_b8 = 0; m_ba = 1; m_bc = 2; m_mir = 0;
      foreach (m_chr[i]) m_chr[i] = 0;
      e_rom = 0; e_prg = 0; e_ren = 0; e_rwe = 0; e_raddr = 0; e_ob = 0; e_obd = 0;
      e_cen = 0; e_cwe = 0; e_caddr = 0; e_mir = 0;
      t_cpu = "R10"; t_chr = "R10";
    end else begin
      int win, bank, off;
      bit rsel, rok;
      win = cpu_addr >> 13; off = cpu_addr & 16'h1FFF;
      rsel = (win == 3) && ((m_low & 8'hC0) == 8'hC0);
      rok = rsel && ((m_low & 6'h3F) < (1 << WB));
      case (win)
        3: bank = m_low & 6'h3F;
        4: bank = m_b8;
        5: bank = m_ba;
        6: bank = m_bc;
        7: bank = 255;
        default: bank = 0;
      endcase
      e_rom = cpu_rd && (win >= 4 || (win == 3 && !rsel));
      e_prg = ((bank & ((1 << PB) - 1)) << 13) | off;
      e_ren = (cpu_rd || cpu_wr) && rok;
      e_rwe = cpu_wr && rok;
      e_raddr = (((m_low & 6'h3F) & ((1 << WB) - 1)) << 13) | off;
      e_ob = cpu_rd && rsel && !rok;
      e_obd = cpu_addr >> 8;
      e_mir = m_mir;
      if (win >= 4 && win <= 6) t_cpu = "R4";
      else if (win == 7) t_cpu = "R5";
      else if (win == 3) t_cpu = rsel && !rok ? "R7" : "R6";
      else t_cpu = "R12";
      if (phase != "") t_cpu = phase;
      e_cen = !ppu_addr[13] && (ppu_rd || ppu_wr);
      e_cwe = (CR != 0) && !ppu_addr[13] && ppu_wr;
      e_caddr = ((m_chr[(ppu_addr >> 10) & 7] & ((1 << CB) - 1)) << 10) | (ppu_addr & 10'h3FF);
      t_chr = (cpu_wr && win == 5 && m_cmd < 8) ? "R11" : (ppu_wr ? "R9" : "R8");
      if (cpu_wr && win == 4) m_cmd = cpu_wdata & 4'hF;
      if (cpu_wr && win == 5) begin
        if (m_cmd < 8) m_chr[m_cmd] = cpu_wdata;
        else if (m_cmd == 8) m_low = cpu_wdata;
        else if (m_cmd == 9) m_b8 = cpu_wdata;
        else if (m_cmd == 10) m_ba = cpu_wdata;
        else if (m_cmd == 11) m_bc = cpu_wdata;
        else if (m_cmd == 12) m_mir = cpu_wdata & 3;
      end
    end
  end

  always @(negedge clk) begin
    if (model_live) begin
      check(t_cpu, prg_rom_en, e_rom, "prg_rom_en");
      if (e_rom) check(t_cpu, prg_addr, e_prg, "prg_addr");
      check(t_cpu, wram_en, e_ren, "wram_en");
      check(t_cpu, wram_we, e_rwe, "wram_we");
      if (e_ren) check(t_cpu, wram_addr, e_raddr, "wram_addr");
      check(t_cpu, open_bus_en, e_ob, "open_bus_en");
      if (e_ob) check(t_cpu, open_bus_data, e_obd, "open_bus_data");
      check("R3", mirror_mode, e_mir, "mirror_mode");
      check(t_chr, chr_en, e_cen, "chr_en");
      check(t_chr, chr_we, e_cwe, "chr_we");
      if (e_cen) check(t_chr, chr_addr, e_caddr, "chr_addr");
    end
  end

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input bit rd, input bit wr,
                     input logic [13:0] pa = 14'h0, input bit prd = 0, input bit pwr = 0);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    ppu_addr = pa; ppu_rd = prd; ppu_wr = pwr;
  endtask

  task automatic setreg(input int c, input int d);
    bus(16'h8000, 8'(c), 0, 1);
    bus(16'hA000, 8'(d), 0, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    model_live = 1;
    phase = "R10";
    bus(16'h8010, 0, 1, 0, 14'h0005, 1);
    bus(16'hA020, 0, 1, 0, 14'h1C07, 1);
    bus(16'hC030, 0, 1, 0);
    bus(16'h6040, 0, 1, 0);
    phase = "";
    bus(16'hE123, 0, 1, 0);
    bus(16'hFFFF, 0, 1, 0);
    bus(16'h5000, 0, 1, 0);
    bus(16'h9000, 0, 0, 0);
    phase = "R1";
    bus(16'h9FFF, 8'hF9, 0, 1);
    bus(16'hBFFE, 8'h25, 0, 1);
    bus(16'h8ABC, 0, 1, 0);
    phase = "";
    setreg(10, 8'h03); setreg(11, 8'h1F);
    bus(16'hA001, 0, 1, 0); bus(16'hC002, 0, 1, 0);
    setreg(8, 8'h07); bus(16'h6100, 0, 1, 0);
    setreg(8, 8'h41); bus(16'h7F00, 0, 1, 0); bus(16'h7F00, 8'h55, 0, 1);
    setreg(8, 8'h81); bus(16'h6200, 0, 1, 0);
    setreg(8, 8'hC1); bus(16'h6300, 0, 1, 0); bus(16'h7301, 8'h11, 0, 1);
    setreg(8, 8'hC0); bus(16'h6001, 8'h22, 0, 1); bus(16'h6001, 0, 1, 0);
    setreg(8, 8'hC2); bus(16'h7A00, 0, 1, 0); bus(16'h7A00, 8'h33, 0, 1);
    setreg(8, 8'hFF); bus(16'h6BCD, 0, 1, 0);
    setreg(8, 8'h3F); bus(16'h6BCD, 0, 1, 0);
    for (int s = 0; s < 8; s++) begin
      bus(16'h8000, 8'(s), 0, 1);
      bus(16'hA000, 8'(8'h10 + s * 37), 0, 1, 14'((s << 10) | 9), 1);
      bus(16'h0000, 0, 0, 0, 14'((s << 10) | 9), 1);
    end
    bus(16'h0, 0, 0, 0, 14'h0BFF, 0, 1);
    bus(16'h0, 0, 0, 0, 14'h2000, 1, 0);
    bus(16'h0, 0, 0, 0, 14'h3FFF, 0, 1);
    for (int m = 0; m < 4; m++) begin setreg(12, m); bus(16'h0, 0, 0, 0); end
    setreg(12, 8'hFE); bus(16'h0, 0, 0, 0);
    phase = "R2";
    setreg(13, 8'h01); setreg(14, 8'hAA); setreg(15, 8'h03);
    bus(16'h8000, 0, 1, 0, 14'h0400, 1); bus(16'hA000, 0, 1, 0); bus(16'hC000, 0, 1, 0);
    bus(16'h6000, 0, 1, 0);
    phase = "";
    for (int i = 0; i < 64; i++) begin
      bus(16'(16'h4000 + i * 16'h0413), 8'(i), 1, 0, 14'(i * 14'h00B7), 1);
    end
    bus(16'h0, 0, 0, 0);
    @(negedge clk);
    model_live = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule